// File: doc/BRIEF.md
# Reset Cause Status Tracker

This block keeps seven sticky status flags that tell software why the processor last restarted or woke, and picks the address at which execution restarts. Its inputs are one-cycle strobes, one for each restart or wake source. Alongside them come the current power mode, an enable that makes stack faults force a reset, and the two interrupt-priority enables. Each source changes its own mix of flags: it sets some, clears some and leaves the rest alone. The mix depends on the power mode at the moment the strobe arrives.

A watchdog time-out or an interrupt that arrives while the core idles or sleeps counts as a wake, not a reset. For a wake the block raises a resume pulse instead of a reset request, and the restart select points at the next instruction or at an interrupt vector. Software may overwrite the flags through a write strobe. A source event in the same cycle takes precedence over that write. When several strobes coincide, only the one with the highest priority is applied.

Top module: `rst_cause_tracker`

## Requirements
- R1: The flag vector packs seven flags. Bit 0 is the software-reset flag, bit 1 the watchdog flag, bit 2 the power-down flag, bit 3 the power-on flag, bit 4 the brown-out flag, bit 5 stack-full and bit 6 stack-underflow. Both a power-on strobe and the block reset load the vector with 7'b0000111. A power-on strobe also pulses the reset request with restart select 0 (restart at address zero).
- R2: A brown-out strobe sets bits 0, 1 and 2 and clears bit 4. Bits 3, 5 and 6 keep their values. It requests a reset to address zero.
- R3: Power mode is encoded 0 for full power, 1 for run, 2 for idle and 3 for sleep. A master-clear strobe requests a reset to address zero. In full power it changes no flag. In run mode it sets bit 1. In idle or sleep it sets bit 1 and clears bit 2.
- R4: A watchdog strobe in full power or run mode clears bit 1 only and requests a reset to address zero.
- R5: A watchdog strobe in idle or sleep clears bits 1 and 2. It raises the resume pulse with restart select 1 (next instruction) and no reset request.
- R6: An interrupt-wake strobe in idle or sleep clears bit 2 only and raises the resume pulse. Its restart select is 2 (high vector) when the high enable is set, otherwise 3 (low vector) when the low enable is set, otherwise 1. In full power or run mode the strobe is ignored: the flags, the pulses and the select do not change.
- R7: A stack-full strobe sets bit 5 and a stack-underflow strobe sets bit 6. Either one requests a reset to address zero only when the stack-reset enable is 1.
- R8: A software-reset strobe clears bit 0, leaves every other flag unchanged and requests a reset to address zero.
- R9: A software write loads the flag vector, and the new value is visible in the cycle after the strobe. When no event is applied, the flags hold their value. A valid event in the same cycle as a write wins, and the write is dropped.
- R10: When strobes coincide, the one applied is the first present in this order: power-on, brown-out, master clear, watchdog, stack full, stack underflow, software reset, interrupt wake.
- R11: The reset request and the resume pulse are never high together. Each lasts exactly one cycle: the cycle after the strobe. The restart select is valid in that cycle and holds its value until the next reset or wake.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ev_por_i | input | 1 | Power-on strobe |
| ev_bor_i | input | 1 | Brown-out strobe |
| ev_mclr_i | input | 1 | External master-clear strobe |
| ev_wdt_i | input | 1 | Watchdog time-out strobe |
| ev_stkful_i | input | 1 | Stack-full strobe |
| ev_stkunf_i | input | 1 | Stack-underflow strobe |
| ev_swrst_i | input | 1 | Software reset instruction strobe |
| ev_irqwake_i | input | 1 | Interrupt wake strobe |
| pwr_mode_i | input | 2 | Power mode: 0 full, 1 run, 2 idle, 3 sleep |
| stk_rst_en_i | input | 1 | Stack faults force a reset when 1 |
| irq_hi_en_i | input | 1 | High-priority interrupt enable |
| irq_lo_en_i | input | 1 | Low-priority interrupt enable |
| sw_wr_i | input | 1 | Software flag write strobe |
| sw_wdata_i | input | 7 | Software flag write data |
| flags_o | output | 7 | Sticky flag vector |
| rst_req_o | output | 1 | One-cycle reset request |
| resume_o | output | 1 | One-cycle wake-and-resume pulse |
| restart_sel_o | output | 2 | Restart address: 0 zero, 1 next, 2 high vector, 3 low vector |

## Verification
Coincident strobes combined with a same-cycle software write are the hardest case to reach from the ports. Hitting them needs every subset of the eight sources, each in every power mode, with the write data chosen so that a dropped write and an applied write leave different flags. The bench walks all 256 strobe subsets in all four modes. Before each one it preloads the flags with a pattern taken from the subset index, and it writes the inverted pattern in the event cycle. A single-source sweep then covers every mode, stack-enable and interrupt-enable combination from two complementary preloads. This exposes each flag that a source must leave unchanged.

// File: rtl/rct_pkg.sv
package rct_pkg;

  localparam int unsigned NUM_FLAGS = 7;
  localparam int unsigned NUM_SRC   = 8;

  // flag bit positions (software decodes these)
  localparam int unsigned FLG_SWR  = 0;
  localparam int unsigned FLG_WDT  = 1;
  localparam int unsigned FLG_PWD  = 2;
  localparam int unsigned FLG_POR  = 3;
  localparam int unsigned FLG_BOR  = 4;
  localparam int unsigned FLG_SFUL = 5;
  localparam int unsigned FLG_SUNF = 6;

  // source index doubles as priority, 0 is highest
  localparam int unsigned SRC_POR  = 0;
  localparam int unsigned SRC_BOR  = 1;
  localparam int unsigned SRC_MCLR = 2;
  localparam int unsigned SRC_WDT  = 3;
  localparam int unsigned SRC_SFUL = 4;
  localparam int unsigned SRC_SUNF = 5;
  localparam int unsigned SRC_SWR  = 6;
  localparam int unsigned SRC_IRQ  = 7;

  localparam logic [NUM_FLAGS-1:0] FLAGS_COLD = 7'b000_0111;

  typedef enum logic [1:0] {
    MODE_FULL  = 2'd0,
    MODE_RUN   = 2'd1,
    MODE_IDLE  = 2'd2,
    MODE_SLEEP = 2'd3
  } pwr_mode_e;

  typedef enum logic [1:0] {
    SEL_ZERO   = 2'd0,
    SEL_NEXT   = 2'd1,
    SEL_VEC_HI = 2'd2,
    SEL_VEC_LO = 2'd3
  } restart_sel_e;

  typedef struct packed {
    logic [NUM_FLAGS-1:0] set_m;
    logic [NUM_FLAGS-1:0] clr_m;
    logic                 upd;
    logic                 do_rst;
    logic                 do_wake;
    restart_sel_e         sel;
  } action_t;

endpackage

// File: rtl/rct_prio_arb.sv
module rct_prio_arb #(
  parameter int unsigned N = 8
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] grant_o,
  output logic         any_o
);

  logic [N:0] seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < N; i++) begin : g_stage
    assign grant_o[i]  = req_i[i] & ~seen[i];
    assign seen[i+1]   = seen[i] | req_i[i];
  end

  assign any_o = seen[N];

  // R10: at most one winner, and only among requesters
  always_comb begin
    if (!$isunknown(req_i)) begin
      p_grant_onehot_r10: assert ($onehot0(grant_o) && ((grant_o & ~req_i) == '0))
        else $error("arbiter granted more than one or a non-requester");
    end
  end

endmodule

// File: rtl/rct_rule_map.sv
module rct_rule_map
  import rct_pkg::*;
#(
  parameter int unsigned N = NUM_SRC
) (
  input  logic [N-1:0] grant_i,
  input  pwr_mode_e    mode_i,
  input  logic         stk_rst_en_i,
  input  logic         irq_hi_en_i,
  input  logic         irq_lo_en_i,
  output action_t      act_o
);

  logic managed;
  assign managed = (mode_i == MODE_IDLE) || (mode_i == MODE_SLEEP);

  always_comb begin
    act_o = '0;
    act_o.sel = SEL_ZERO;
    if (grant_i[SRC_POR]) begin
      act_o.upd    = 1'b1;
      act_o.do_rst = 1'b1;
      act_o.set_m  = FLAGS_COLD;
      act_o.clr_m  = ~FLAGS_COLD;
    end else if (grant_i[SRC_BOR]) begin
      act_o.upd    = 1'b1;
      act_o.do_rst = 1'b1;
      act_o.set_m[FLG_SWR] = 1'b1;
      act_o.set_m[FLG_WDT] = 1'b1;
      act_o.set_m[FLG_PWD] = 1'b1;
      act_o.clr_m[FLG_BOR] = 1'b1;
    end else if (grant_i[SRC_MCLR]) begin
      act_o.upd    = 1'b1;
      act_o.do_rst = 1'b1;
      if (mode_i != MODE_FULL) act_o.set_m[FLG_WDT] = 1'b1;
      if (managed)             act_o.clr_m[FLG_PWD] = 1'b1;
    end else if (grant_i[SRC_WDT]) begin
      act_o.upd = 1'b1;
      act_o.clr_m[FLG_WDT] = 1'b1;
      if (managed) begin
        act_o.clr_m[FLG_PWD] = 1'b1;
        act_o.do_wake        = 1'b1;
        act_o.sel            = SEL_NEXT;
      end else begin
        act_o.do_rst = 1'b1;
      end
    end else if (grant_i[SRC_SFUL]) begin
      act_o.upd    = 1'b1;
      act_o.do_rst = stk_rst_en_i;
      act_o.set_m[FLG_SFUL] = 1'b1;
    end else if (grant_i[SRC_SUNF]) begin
      act_o.upd    = 1'b1;
      act_o.do_rst = stk_rst_en_i;
      act_o.set_m[FLG_SUNF] = 1'b1;
    end else if (grant_i[SRC_SWR]) begin
      act_o.upd    = 1'b1;
      act_o.do_rst = 1'b1;
      act_o.clr_m[FLG_SWR] = 1'b1;
    end else if (grant_i[SRC_IRQ] && managed) begin
      act_o.upd     = 1'b1;
      act_o.do_wake = 1'b1;
      act_o.clr_m[FLG_PWD] = 1'b1;
      if (irq_hi_en_i)      act_o.sel = SEL_VEC_HI;
      else if (irq_lo_en_i) act_o.sel = SEL_VEC_LO;
      else                  act_o.sel = SEL_NEXT;
    end
  end

  // R11: a source is either a reset or a wake, never both
  always_comb begin
    if (!$isunknown(grant_i)) begin
      p_rst_or_wake_r11: assert (!(act_o.do_rst && act_o.do_wake))
        else $error("action requests reset and wake together");
    end
  end

endmodule

// File: rtl/rct_flag_bank.sv
module rct_flag_bank
  import rct_pkg::*;
#(
  parameter int unsigned W = NUM_FLAGS
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sw_wr_i,
  input  logic [W-1:0] sw_wdata_i,
  input  logic         upd_i,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] flags_o
);

  logic [W-1:0] flags_q;
  logic [W-1:0] flags_d;
  logic         flags_en;

  assign flags_en = upd_i | sw_wr_i;

  always_comb begin
    if (upd_i) flags_d = (flags_q & ~clr_i) | set_i;
    else       flags_d = sw_wdata_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       flags_q <= FLAGS_COLD;
    else if (flags_en) flags_q <= flags_d;
  end

  assign flags_o = flags_q;

  p_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sw_wr_i && !upd_i) |=> $stable(flags_o))
    else $error("flags moved without write or event");

  p_write_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sw_wr_i && !upd_i) |=> (flags_o == $past(sw_wdata_i)))
    else $error("software write not loaded");

  p_event_wins_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    upd_i |=> (((flags_o & $past(set_i)) == $past(set_i)) && ((flags_o & $past(clr_i)) == '0)))
    else $error("event masks not applied");

endmodule

// File: rtl/rst_cause_tracker.sv
module rst_cause_tracker
  import rct_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       ev_por_i,
  input  logic       ev_bor_i,
  input  logic       ev_mclr_i,
  input  logic       ev_wdt_i,
  input  logic       ev_stkful_i,
  input  logic       ev_stkunf_i,
  input  logic       ev_swrst_i,
  input  logic       ev_irqwake_i,
  input  logic [1:0] pwr_mode_i,
  input  logic       stk_rst_en_i,
  input  logic       irq_hi_en_i,
  input  logic       irq_lo_en_i,
  input  logic       sw_wr_i,
  input  logic [6:0] sw_wdata_i,
  output logic [6:0] flags_o,
  output logic       rst_req_o,
  output logic       resume_o,
  output logic [1:0] restart_sel_o
);

  // reset: asynchronous assert, synchronous release
  logic [SYNC_STAGES-1:0] rsync_q;
  logic                   rst_n_int;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rsync_q <= '0;
    else         rsync_q <= {rsync_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_n_int = rsync_q[SYNC_STAGES-1];

  // source vector in priority order
  logic [NUM_SRC-1:0] req;
  logic [NUM_SRC-1:0] grant;
  logic               any_req;
  action_t            act;
  pwr_mode_e          mode;

  assign mode = pwr_mode_e'(pwr_mode_i);

  always_comb begin
    req           = '0;
    req[SRC_POR]  = ev_por_i;
    req[SRC_BOR]  = ev_bor_i;
    req[SRC_MCLR] = ev_mclr_i;
    req[SRC_WDT]  = ev_wdt_i;
    req[SRC_SFUL] = ev_stkful_i;
    req[SRC_SUNF] = ev_stkunf_i;
    req[SRC_SWR]  = ev_swrst_i;
    req[SRC_IRQ]  = ev_irqwake_i;
  end

  rct_prio_arb #(.N(NUM_SRC)) u_arb (
    .req_i   (req),
    .grant_o (grant),
    .any_o   (any_req)
  );

  rct_rule_map #(.N(NUM_SRC)) u_rules (
    .grant_i      (grant),
    .mode_i       (mode),
    .stk_rst_en_i (stk_rst_en_i),
    .irq_hi_en_i  (irq_hi_en_i),
    .irq_lo_en_i  (irq_lo_en_i),
    .act_o        (act)
  );

  rct_flag_bank #(.W(NUM_FLAGS)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_n_int),
    .sw_wr_i    (sw_wr_i),
    .sw_wdata_i (sw_wdata_i),
    .upd_i      (act.upd),
    .set_i      (act.set_m),
    .clr_i      (act.clr_m),
    .flags_o    (flags_o)
  );

  // redirect outputs
  logic         rst_req_q, rst_req_d;
  logic         resume_q,  resume_d;
  restart_sel_e sel_q,     sel_d;
  logic         sel_en;

  assign sel_en = any_req & (act.do_rst | act.do_wake);

  always_comb begin
    rst_req_d = act.do_rst;
    resume_d  = act.do_wake;
    sel_d     = act.sel;
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int) begin
      rst_req_q <= 1'b0;
      resume_q  <= 1'b0;
    end else begin
      rst_req_q <= rst_req_d;
      resume_q  <= resume_d;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n_int) begin
    if (!rst_n_int)  sel_q <= SEL_ZERO;
    else if (sel_en) sel_q <= sel_d;
  end

  assign rst_req_o     = rst_req_q;
  assign resume_o      = resume_q;
  assign restart_sel_o = sel_q;

  p_por_r1: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    ev_por_i |=> (flags_o == FLAGS_COLD) && rst_req_o && (restart_sel_o == SEL_ZERO))
    else $error("power-on response wrong");

  p_bor_r2: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (ev_bor_i && !ev_por_i) |=> !flags_o[FLG_BOR] && flags_o[FLG_SWR] && rst_req_o)
    else $error("brown-out response wrong");

  p_wdt_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (ev_wdt_i && !ev_por_i && !ev_bor_i && !ev_mclr_i && pwr_mode_i[1])
      |=> resume_o && !rst_req_o && (restart_sel_o == SEL_NEXT) && !flags_o[FLG_WDT])
    else $error("watchdog wake wrong");

  p_irq_hi_r6: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (ev_irqwake_i && (req[NUM_SRC-2:0] == '0) && pwr_mode_i[1] && irq_hi_en_i)
      |=> resume_o && (restart_sel_o == SEL_VEC_HI) && !flags_o[FLG_PWD])
    else $error("interrupt wake vector wrong");

  p_stk_noreset_r7: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (ev_stkunf_i && (req[SRC_SUNF-1:0] == '0) && !stk_rst_en_i)
      |=> flags_o[FLG_SUNF] && !rst_req_o)
    else $error("underflow without enable misbehaved");

  p_swrst_r8: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (ev_swrst_i && (req[SRC_SWR-1:0] == '0)) |=> !flags_o[FLG_SWR] && rst_req_o)
    else $error("software reset response wrong");

  p_excl_r11: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    !(rst_req_o && resume_o))
    else $error("reset and resume together");

  p_quiet_r11: assert property (@(posedge clk_i) disable iff (!rst_n_int)
    (req == '0) |=> !rst_req_o && !resume_o && $stable(restart_sel_o))
    else $error("pulse or select moved without a source");

endmodule

// File: tb/rst_cause_tracker_tb.sv
module rst_cause_tracker_tb_top;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [7:0] req;
  logic [1:0] mode;
  logic       en, hi, lo, wr;
  logic [6:0] wd;
  logic [6:0] flags;
  logic       rreq, resm;
  logic [1:0] sel;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  logic [6:0] e_flags;
  logic [1:0] e_sel;

  always #2.5 clk = ~clk;

  rst_cause_tracker dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .ev_por_i(req[0]), .ev_bor_i(req[1]), .ev_mclr_i(req[2]), .ev_wdt_i(req[3]),
    .ev_stkful_i(req[4]), .ev_stkunf_i(req[5]), .ev_swrst_i(req[6]), .ev_irqwake_i(req[7]),
    .pwr_mode_i(mode), .stk_rst_en_i(en), .irq_hi_en_i(hi), .irq_lo_en_i(lo),
    .sw_wr_i(wr), .sw_wdata_i(wd),
    .flags_o(flags), .rst_req_o(rreq), .resume_o(resm), .restart_sel_o(sel)
  );

  task automatic chk(input string tag, input string what, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // expected behaviour from the requirements: {reset, wake, sel, flags}
  function automatic logic [10:0] model(input logic [7:0] rq, input logic w, input logic [6:0] d,
                                        input logic [1:0] md, input logic se, input logic h,
                                        input logic l, input logic [6:0] f, input logic [1:0] s);
    logic [6:0] nf;
    logic       r, k, mg;
    logic [1:0] ns;
    nf = f; r = 1'b0; k = 1'b0; ns = s; mg = md[1];
    if (rq[0]) begin
      nf = 7'b0000111; r = 1'b1; ns = 2'd0;
    end else if (rq[1]) begin
      nf[0] = 1'b1; nf[1] = 1'b1; nf[2] = 1'b1; nf[4] = 1'b0; r = 1'b1; ns = 2'd0;
    end else if (rq[2]) begin
      if (md == 2'd1) nf[1] = 1'b1;
      if (mg) begin nf[1] = 1'b1; nf[2] = 1'b0; end
      r = 1'b1; ns = 2'd0;
    end else if (rq[3]) begin
      nf[1] = 1'b0;
      if (mg) begin nf[2] = 1'b0; k = 1'b1; ns = 2'd1; end
      else begin r = 1'b1; ns = 2'd0; end
    end else if (rq[4]) begin
      nf[5] = 1'b1;
      if (se) begin r = 1'b1; ns = 2'd0; end
    end else if (rq[5]) begin
      nf[6] = 1'b1;
      if (se) begin r = 1'b1; ns = 2'd0; end
    end else if (rq[6]) begin
      nf[0] = 1'b0; r = 1'b1; ns = 2'd0;
    end else if (rq[7] && mg) begin
      nf[2] = 1'b0; k = 1'b1;
      ns = h ? 2'd2 : (l ? 2'd3 : 2'd1);
    end else if (w) begin
      nf = d;
    end
    return {r, k, ns, nf};
  endfunction

  function automatic string tag_of(input logic [7:0] rq, input logic w, input logic [1:0] md);
    if (rq[0]) return "R1";
    if (rq[1]) return "R2";
    if (rq[2]) return "R3";
    if (rq[3]) return md[1] ? "R5" : "R4";
    if (rq[4] || rq[5]) return "R7";
    if (rq[6]) return "R8";
    if (rq[7]) return "R6";
    if (w) return "R9";
    return "R11";
  endfunction

  // called at a negedge; drives, clocks once, checks at the next negedge
  task automatic step(input logic [7:0] rq, input logic w, input logic [6:0] d, input logic [1:0] md,
                      input logic se, input logic h, input logic l, input string tag);
    logic [10:0] e;
    req = rq; wr = w; wd = d; mode = md; en = se; hi = h; lo = l;
    e = model(rq, w, d, md, se, h, l, e_flags, e_sel);
    @(posedge clk);
    @(negedge clk);
    chk(tag, "flags", flags, e[6:0]);
    chk(tag, "rst_req", {6'd0, rreq}, {6'd0, e[10]});
    chk(tag, "resume", {6'd0, resm}, {6'd0, e[9]});
    chk(tag, "sel", {5'd0, sel}, {5'd0, e[8:7]});
    e_flags = e[6:0];
    e_sel   = e[8:7];
    req = '0; wr = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; req = '0; mode = '0; en = 1'b0; hi = 1'b0; lo = 1'b0; wr = 1'b0; wd = '0;
    repeat (3) @(negedge clk);
    // R1: block reset state
    chk("R1", "flags in reset", flags, 7'h07);
    chk("R1", "rst_req in reset", {6'd0, rreq}, 7'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "flags after release", flags, 7'h07);
    chk("R1", "sel after release", {5'd0, sel}, 7'd0);
    chk("R11", "resume after release", {6'd0, resm}, 7'd0);
    e_flags = 7'h07;
    e_sel   = 2'd0;

    // single-source sweep over modes, enables and preload patterns
    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 8; s++)
        for (int se = 0; se < 2; se++)
          for (int ie = 0; ie < 4; ie++)
            for (int p = 0; p < 2; p++) begin
              logic [6:0] pat;
              logic [7:0] one;
              pat = (p == 0) ? 7'h2A : 7'h55;
              one = 8'd1 << s;
              step('0, 1'b1, pat, 2'(m), se[0], ie[1], ie[0], "R9");
              step(one, 1'b0, '0, 2'(m), se[0], ie[1], ie[0], tag_of(one, 1'b0, 2'(m)));
              step('0, 1'b0, '0, 2'(m), se[0], ie[1], ie[0], "R11");
            end

    // R10: every subset of coincident sources, with a competing software write
    for (int m = 0; m < 4; m++)
      for (int r = 0; r < 256; r++) begin
        logic [7:0] rv;
        rv = 8'(r);
        step('0, 1'b1, rv[6:0], 2'(m), 1'b0, 1'b0, 1'b0, "R9");
        step(rv, 1'b1, ~rv[6:0], 2'(m), rv[2], rv[1], rv[0], "R10");
      end

    // R1: asynchronous reset mid-run restores the cold value at once
    step('0, 1'b1, 7'h78, 2'd0, 1'b0, 1'b0, 1'b0, "R9");
    #1 rst_n = 1'b0;
    #1;
    chk("R1", "flags on async reset", flags, 7'h07);
    chk("R1", "rst_req on async reset", {6'd0, rreq}, 7'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    e_flags = 7'h07;
    e_sel   = 2'd0;
    step(8'h40, 1'b0, '0, 2'd0, 1'b0, 1'b0, 1'b0, "R8");

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule